// File: doc/BRIEF.md
# Counter-Based Keyed Random Word Generator

This block produces a stream of 32-bit pseudo-random words from a 64-bit key and a 128-bit counter. It does not step a state register. Each 128-bit output block is a pure function of the counter value and the key. A keyed mixer computes it over several rounds, and each round multiplies two counter words by fixed odd constants and XORs the high and low product halves back together. The key is bumped by fixed increments between rounds.

Software starts a stream with one load strobe. The strobe carries a seed, which becomes the key, a subsequence index, which fills the upper half of the counter, and a skip count, which is the number of 128-bit blocks to pass over. A consumer then takes words one at a time through a valid/ready handshake. The four words of each block are buffered and handed out lowest word first. The next block is computed only after the fourth word has been accepted, and the counter then advances by one.

The mixer runs one round per clock with a single pair of 32x32 multipliers. A block therefore costs one setup cycle plus one cycle per round. The round count is a runtime input.

Top module: `ctr_mix_rng`

## Requirements
- R1: A load strobe sets key word 0 to seed bits [31:0] and key word 1 to seed bits [63:32]. It sets counter words 3..2 (counter bits [127:64]) to the subsequence and counter words 1..0 to the skip count. The counter word i is bits [32i+31:32i].
- R2: After reset the key equals 67280421310721, the counter is zero and no word is valid.
- R3: Each round computes p0 = 0xD2511F53*c0 and p1 = 0xCD9E8D57*c2 as full 64-bit products. The new counter words are: c0' = p1[63:32]^c1^k0, c1' = p1[31:0], c2' = p0[63:32]^c3^k1, c3' = p0[31:0].
- R4: Between consecutive rounds of one block, k0 increases by 0x9E3779B9 and k1 increases by 0xBB67AE85, both modulo 2^32. The stored key does not change from block to block.
- R5: The round count is sampled when a block starts, and a count of 0 is treated as 1. After a load, valid rises N+1 clock edges after the load edge, where N is the effective round count.
- R6: The words of a block come out in the order word 0, 1, 2, 3, and the word index advances on each cycle with valid_o and ready_i both high.
- R7: A new block is computed only after word 3 has been accepted. The 128-bit counter then increases by one, and the carry ripples from word 0 to word 3 and wraps modulo 2^128.
- R8: The skip count is a number of 128-bit blocks added to the low 64 bits of the cleared counter. Later increments carry out of bit 63 into the subsequence half.
- R9: A load discards any buffered words and restarts the stream at word 0 of the new first block. valid_o is low in the load cycle.
- R10: While valid_o is high and ready_i is low, word_o holds its value.
- R11: busy_o is high and valid_o is low while a block is being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load seed, subsequence and skip count |
| seed_i | input | 64 | Key value |
| subseq_i | input | 64 | Subsequence index, goes to counter bits [127:64] |
| skip_i | input | 64 | Number of 128-bit blocks to skip |
| rounds_i | input | RND_W | Rounds per block (0 means 1) |
| ready_i | input | 1 | Consumer accepts word_o |
| valid_o | output | 1 | word_o holds a fresh word |
| word_o | output | 32 | Random word |
| busy_o | output | 1 | A block is being computed |

## Verification
The bench computes every word arithmetically from the round and key-bump equations. It compares full multi-block streams for the reset default and for several seed, subsequence and skip combinations. Round counts of 10, 7, 1 and 0 separate key-bump mistakes from round-count handling: with one round no bump is applied at all. A skip count of all ones catches a missing carry out of bit 63 on the next block, and an all-ones subsequence adds a full 128-bit wrap. Stalls, mid-block reloads and latency counts check the handshake, the buffer restart and the one-round-per-cycle timing.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int WORD_W  = 32;
  localparam int WORDS   = 4;
  localparam int BLK_W   = WORD_W * WORDS;
  localparam int KEY_W   = 2 * WORD_W;
  localparam logic [KEY_W-1:0]  DEF_SEED = 64'd67280421310721;
  localparam logic [WORD_W-1:0] MUL_A  = 32'hD2511F53;
  localparam logic [WORD_W-1:0] MUL_B  = 32'hCD9E8D57;
  localparam logic [WORD_W-1:0] BUMP_0 = 32'h9E3779B9;
  localparam logic [WORD_W-1:0] BUMP_1 = 32'hBB67AE85;

  typedef enum logic [1:0] {ST_FILL, ST_RUN, ST_OUT} st_t;

  function automatic logic [KEY_W-1:0] key_bump(input logic [KEY_W-1:0] k);
    return {k[KEY_W-1:WORD_W] + BUMP_1, k[WORD_W-1:0] + BUMP_0};
  endfunction
endpackage

// File: rtl/rng_round.sv
module rng_round
  import rng_pkg::*;
(
  input  logic [BLK_W-1:0] x_i,
  input  logic [KEY_W-1:0] k_i,
  output logic [BLK_W-1:0] y_o
);
  logic [2*WORD_W-1:0] p0, p1;
  logic [WORD_W-1:0] c [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_split
    assign c[i] = x_i[i*WORD_W +: WORD_W];
  end

  assign p0 = {{WORD_W{1'b0}}, MUL_A} * {{WORD_W{1'b0}}, c[0]};
  assign p1 = {{WORD_W{1'b0}}, MUL_B} * {{WORD_W{1'b0}}, c[2]};

  assign y_o = {p0[WORD_W-1:0],
                p0[2*WORD_W-1:WORD_W] ^ c[3] ^ k_i[KEY_W-1:WORD_W],
                p1[WORD_W-1:0],
                p1[2*WORD_W-1:WORD_W] ^ c[1] ^ k_i[WORD_W-1:0]};
endmodule

// File: rtl/rng_ctr.sv
module rng_ctr
  import rng_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [KEY_W-1:0]   subseq_i,
  input  logic [KEY_W-1:0]   skip_i,
  input  logic               step_i,
  output logic [BLK_W-1:0]   ctr_o
);
  localparam int HALF = BLK_W / 2;
  logic [BLK_W-1:0] ctr_q;

  function automatic logic [BLK_W-1:0] add_lo(input logic [BLK_W-1:0] c,
                                              input logic [HALF-1:0] a);
    return c + {{(BLK_W-HALF){1'b0}}, a};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctr_q <= '0;
    else if (load_i) ctr_q <= add_lo({subseq_i, {HALF{1'b0}}}, skip_i);
    else if (step_i) ctr_q <= add_lo(ctr_q, HALF'(1));
  end

  assign ctr_o = ctr_q;

  AST_CTR_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && ctr_q[HALF-1:0] != {HALF{1'b1}}) |=>
      ctr_q[BLK_W-1:HALF] == $past(ctr_q[BLK_W-1:HALF])); // R7
endmodule

// File: rtl/rng_obuf.sv
module rng_obuf
  import rng_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic               adv_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               last_o
);
  localparam int IDX_W = $clog2(WORDS);
  logic [BLK_W-1:0] blk_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (wr_i) begin
      blk_q <= blk_i;
      idx_q <= '0;
    end else if (adv_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign word_o = blk_q[idx_q*WORD_W +: WORD_W];
  assign last_o = (idx_q == IDX_W'(WORDS-1));

  AST_IDX_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || clr_i) |=> !last_o); // R6
endmodule

// File: rtl/ctr_mix_rng.sv
module ctr_mix_rng
  import rng_pkg::*;
#(
  parameter int RND_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [63:0]       seed_i,
  input  logic [63:0]       subseq_i,
  input  logic [63:0]       skip_i,
  input  logic [RND_W-1:0]  rounds_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [31:0]       word_o,
  output logic              busy_o
);
  st_t              st_q;
  logic [KEY_W-1:0] key_q, kr_q;
  logic [BLK_W-1:0] x_q, y, ctr;
  logic [RND_W-1:0] rnd_q, nr_q;
  logic             last_rnd, done, fire, last_word;

  assign last_rnd = (rnd_q == nr_q - 1'b1);
  assign done     = (st_q == ST_RUN) && last_rnd && !load_i;
  assign valid_o  = (st_q == ST_OUT) && !load_i;
  assign busy_o   = (st_q != ST_OUT);
  assign fire     = valid_o && ready_i;

  rng_round u_round (.x_i(x_q), .k_i(kr_q), .y_o(y));

  rng_ctr u_ctr (
    .clk_i, .rst_ni, .load_i, .subseq_i, .skip_i,
    .step_i(done), .ctr_o(ctr)
  );

  rng_obuf u_obuf (
    .clk_i, .rst_ni, .clr_i(load_i), .wr_i(done), .blk_i(y),
    .adv_i(fire), .word_o, .last_o(last_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FILL;
      key_q <= DEF_SEED;
      kr_q  <= '0;
      x_q   <= '0;
      rnd_q <= '0;
      nr_q  <= RND_W'(1);
    end else if (load_i) begin
      st_q  <= ST_FILL;
      key_q <= seed_i;
    end else begin
      unique case (st_q)
        ST_FILL: begin
          x_q   <= ctr;
          kr_q  <= key_q;
          rnd_q <= '0;
          nr_q  <= (rounds_i == '0) ? RND_W'(1) : rounds_i;
          st_q  <= ST_RUN;
        end
        ST_RUN: begin
          if (last_rnd) begin
            st_q <= ST_OUT;
          end else begin
            x_q   <= y;
            kr_q  <= key_bump(kr_q);
            rnd_q <= rnd_q + 1'b1;
          end
        end
        ST_OUT:  if (fire && last_word) st_q <= ST_FILL;
        default: st_q <= ST_FILL;
      endcase
    end
  end

  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o); // R11
  AST_KEY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(key_q)); // R4
  AST_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && last_word && !load_i) |=> busy_o); // R7
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> $stable(word_o)); // R10
  AST_LOAD_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o); // R9
endmodule

// File: tb/sim_ctr_mix_rng.sv
module sim_ctr_mix_rng;
  localparam int RW = 5;
  logic clk = 0, rst_n = 0, load = 0, rdy = 0;
  logic [63:0] seed = '0, sub = '0, skip = '0;
  logic [RW-1:0] rounds = 5'd10;
  logic valid, busy;
  logic [31:0] word;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ctr_mix_rng #(.RND_W(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed_i(seed),
    .subseq_i(sub), .skip_i(skip), .rounds_i(rounds), .ready_i(rdy),
    .valid_o(valid), .word_o(word), .busy_o(busy)
  );

  function automatic logic [127:0] ref_block(logic [127:0] c, logic [63:0] k, int nr);
    logic [63:0] p0, p1;
    if (nr == 0) nr = 1;
    for (int r = 0; r < nr; r++) begin
      p0 = 64'(32'hD2511F53) * 64'(c[31:0]);
      p1 = 64'(32'hCD9E8D57) * 64'(c[95:64]);
      c = {p0[31:0], p0[63:32] ^ c[127:96] ^ k[63:32],
           p1[31:0], p1[63:32] ^ c[63:32] ^ k[31:0]};
      k = {k[63:32] + 32'hBB67AE85, k[31:0] + 32'h9E3779B9};
    end
    return c;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic get_word(output logic [31:0] w);
    int t = 0;
    while (!valid && t < 200) begin @(negedge clk); t++; end
    w = word;
    rdy = 1;
    @(negedge clk);
    rdy = 0;
  endtask

  task automatic do_load(logic [63:0] s, logic [63:0] q, logic [63:0] o, int nr);
    @(negedge clk);
    seed = s; sub = q; skip = o; rounds = RW'(nr); load = 1;
    @(negedge clk);
    load = 0;
  endtask

  task automatic run_stream(string req, logic [63:0] s, logic [127:0] c0, int nr, int nblk);
    logic [127:0] b;
    logic [31:0] w;
    for (int bi = 0; bi < nblk; bi++) begin
      b = ref_block(c0 + 128'(bi), s, nr);
      for (int wi = 0; wi < 4; wi++) begin
        get_word(w);
        check(req, 128'(w), 128'(b[wi*32 +: 32]));
      end
    end
  endtask

  task automatic latency(string req, int nr);
    int cnt = 0;
    int eff = (nr == 0) ? 1 : nr;
    @(negedge clk);
    seed = 64'h1234; sub = '0; skip = '0; rounds = RW'(nr); load = 1;
    @(posedge clk);
    @(negedge clk);
    load = 0;
    check({req, " busy while computing"}, 128'({busy, valid}), 128'(2'b10));
    while (!valid && cnt < 100) begin @(posedge clk); cnt++; @(negedge clk); end
    check(req, 128'(cnt), 128'(eff + 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w, w2;
    logic [127:0] b;
    repeat (2) @(negedge clk);
    // R2: reset state
    check("R2 reset valid", 128'(valid), 128'(0));
    check("R2 reset busy", 128'(busy), 128'(1));
    rst_n = 1;
    run_stream("R2 default seed stream", 64'd67280421310721, 128'd0, 10, 2);

    // R1 R3 R4 R6 R7: several seeds, subsequences, round counts
    do_load(64'hDEAD_BEEF_0123_4567, 64'd3, 64'd0, 10);
    run_stream("R1 R3 R4 seed/subseq stream", 64'hDEAD_BEEF_0123_4567, {64'd3, 64'd0}, 10, 3);
    do_load(64'h0, 64'h0, 64'd5, 7);
    run_stream("R8 skip 5 rounds 7", 64'h0, 128'd5, 7, 2);
    do_load(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'd9, 1);
    run_stream("R3 single round no bump", 64'hFFFF_FFFF_FFFF_FFFF, {64'd1, 64'd9}, 1, 2);
    do_load(64'h5555_AAAA_0F0F_F0F0, 64'h2, 64'd1, 0);
    run_stream("R5 zero rounds means one", 64'h5555_AAAA_0F0F_F0F0, {64'd2, 64'd1}, 1, 1);

    // R8 R7: carry out of bit 63, then full 128-bit wrap
    do_load(64'hCAFE, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 10);
    run_stream("R8 carry into subsequence", 64'hCAFE, {64'd5, 64'hFFFF_FFFF_FFFF_FFFF}, 10, 2);
    do_load(64'hBEEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 10);
    run_stream("R7 128-bit wrap", 64'hBEEF, {128{1'b1}}, 10, 2);

    // R10: stall holds word and valid
    do_load(64'h77, 64'd0, 64'd0, 4);
    b = ref_block(128'd0, 64'h77, 4);
    while (!valid) @(negedge clk);
    w = word;
    repeat (5) @(negedge clk);
    check("R10 stall word", 128'(word), 128'(w));
    check("R10 stall valid", 128'(valid), 128'(1));
    check("R10 stall value", 128'(w), 128'(b[31:0]));

    // R9: reload mid block restarts at word 0
    get_word(w2);
    get_word(w2);
    check("R6 third word order", 128'(word), 128'(b[95:64]));
    @(negedge clk);
    seed = 64'h99; sub = '0; skip = '0; rounds = 5'd3; load = 1; rdy = 1;
    #1 check("R9 valid low during load", 128'(valid), 128'(0));
    @(negedge clk);
    load = 0; rdy = 0;
    run_stream("R9 restart after reload", 64'h99, 128'd0, 3, 1);

    // R5 R11: latency and busy
    latency("R5 latency 10 rounds", 10);
    latency("R5 latency 1 round", 1);
    latency("R5 latency 0 rounds", 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule